// File: doc/BRIEF.md
# Fetch Thread Picker

This block decides, every cycle, which hardware thread of a multithreaded core is allowed to fetch. It looks at a status code for each thread, a mask of threads that are currently active and a policy select. From these it produces a thread number and a valid flag. The result is combinational and is available in the same cycle as the inputs.

The rotating policy keeps an ordered list of thread numbers. It grants the first entry in that list whose thread is both active and able to fetch. When the consumer asserts the advance strobe, the granted thread leaves its position and joins the tail of the list at the next clock edge. Two simpler policies are also offered. One always names thread 0. The other looks only at the lowest-numbered active thread. A core built with a single thread skips policy selection altogether.

Top module: `fetch_thread_pick`

## Requirements
- R1: Status codes are 3 bits wide. 0 = running, 1 = idle and 4 = fill-done can fetch. Codes 2, 3, 5, 6 and 7 cannot. The policies that filter by status (codes 1 and 2 in R3 and R7, and the single-thread path of R8) never report a thread whose code cannot fetch.
- R2: After reset the rotation list holds 0,1,2,3 from the front. With every thread active and running, repeated grants with advance therefore come out as 0,1,2,3,0.
- R3: Policy code 1 (rotating) grants the first list entry whose thread is active and can fetch, scanning from the front.
- R4: Under policy 1, a valid grant with `advance` high moves the granted thread to the tail of the list at the next rising edge. The other entries keep their relative order. With `advance` low the list is unchanged.
- R5: When no thread qualifies under policy 1, `pick_valid` is low and the list is left unchanged, even if `advance` is high.
- R6: Policy code 0, with more than one thread configured, returns thread 0 with valid high, whatever the status and mask inputs are.
- R7: Policy code 2 examines only the lowest-numbered active thread. It returns that thread if its status can fetch. Otherwise, or when no thread is active, it returns none.
- R8: With NUM_THREADS = 1 the result is thread 0 when active bit 0 is set and its status can fetch, and none otherwise. This holds for every policy code.
- R9: Policy code 3 is unsupported and gives `pick_valid` low when more than one thread is configured.
- R10: When `pick_valid` is low, `pick_tid` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_status | input | 3*NUM_THREADS | Per-thread status code; thread i in bits [3i+2:3i] |
| thr_active | input | NUM_THREADS | Active-thread mask, bit i for thread i |
| policy_sel | input | 2 | 0 single, 1 rotating, 2 first-active, 3 unsupported |
| advance | input | 1 | Commit the current rotating grant into the list order |
| pick_tid | output | 2 | Selected thread number |
| pick_valid | output | 1 | A thread is selected |

## Verification
The selection outputs are due in the same cycle the inputs change. The list rotation is due at the next rising edge and shows up in the first selection made after it. The bench drives its inputs at the falling edge and samples 1 ns later, well before the rising edge. Its reference list is updated only at the rising edge, so each check compares against the list state that was in force when the inputs were applied. A four-thread and a one-thread instance are both driven through directed cases and several thousand pseudo-random cycles across all policy codes.

// File: rtl/fetch_pick_pkg.sv
package fetch_pick_pkg;
  localparam int MAX_THREADS = 4;
  localparam int TID_W       = 2;
  localparam int STAT_W      = 3;

  typedef enum logic [STAT_W-1:0] {
    ST_RUN       = 3'd0,
    ST_IDLE      = 3'd1,
    ST_SQUASH    = 3'd2,
    ST_BLOCK     = 3'd3,
    ST_FILL_DONE = 3'd4,
    ST_WAIT_FILL = 3'd5,
    ST_WAIT_SLOT = 3'd6,
    ST_RSVD      = 3'd7
  } fstat_e;

  typedef enum logic [1:0] {
    POL_SOLO      = 2'd0,
    POL_ROTATE    = 2'd1,
    POL_FIRST_ACT = 2'd2,
    POL_BAD       = 2'd3
  } fpol_e;

  function automatic logic stat_can_fetch(input logic [STAT_W-1:0] s);
    return (s == ST_RUN) || (s == ST_IDLE) || (s == ST_FILL_DONE);
  endfunction
endpackage

// File: rtl/fetch_pick_elig.sv
module fetch_pick_elig
  import fetch_pick_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic [NUM_THREADS*STAT_W-1:0] thr_status,
  input  logic [NUM_THREADS-1:0]        thr_active,
  output logic [NUM_THREADS-1:0]        can_fetch,
  output logic [NUM_THREADS-1:0]        cand
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    assign can_fetch[t] = stat_can_fetch(thr_status[t*STAT_W +: STAT_W]);
    assign cand[t]      = can_fetch[t] & thr_active[t];
  end
endmodule

// File: rtl/fetch_pick_rotor.sv
module fetch_pick_rotor
  import fetch_pick_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_THREADS-1:0] cand,
  input  logic                   advance_en,
  output logic                   hit,
  output logic [TID_W-1:0]       hit_tid
);
  localparam int FLAT_W = NUM_THREADS * TID_W;

  logic [TID_W-1:0]       order_q [NUM_THREADS];
  logic [TID_W-1:0]       order_d [NUM_THREADS];
  logic [TID_W-1:0]       pos;
  logic [MAX_THREADS-1:0] cand_pad;
  logic                   order_en;

  assign cand_pad = MAX_THREADS'(cand);

  // scan from the front of the list
  always_comb begin
    hit = 1'b0;
    pos = '0;
    for (int p = 0; p < NUM_THREADS; p++) begin
      if (!hit && cand_pad[order_q[p]]) begin
        hit = 1'b1;
        pos = TID_W'(p);
      end
    end
  end

  assign hit_tid  = hit ? order_q[pos] : '0;
  assign order_en = advance_en & hit;

  // winner to the tail, entries behind it shift forward
  always_comb begin
    for (int i = 0; i < NUM_THREADS; i++) begin
      int j;
      j = (i == NUM_THREADS - 1) ? i : i + 1;
      if (int'(pos) > i)             order_d[i] = order_q[i];
      else if (i == NUM_THREADS - 1) order_d[i] = order_q[pos];
      else                           order_d[i] = order_q[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= TID_W'(i);
    end else if (order_en) begin
      for (int i = 0; i < NUM_THREADS; i++) order_q[i] <= order_d[i];
    end
  end

  // checking support
  logic [FLAT_W-1:0]      order_flat;
  logic [MAX_THREADS-1:0] seen;
  always_comb begin
    seen = '0;
    for (int p = 0; p < NUM_THREADS; p++) begin
      order_flat[p*TID_W +: TID_W] = order_q[p];
      seen[order_q[p]] = 1'b1;
    end
  end

  assert_perm_R4: assert property (@(posedge clk) disable iff (!rst_n)
    seen == MAX_THREADS'((1 << NUM_THREADS) - 1));
  assert_pick_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> cand_pad[hit_tid]);
  assert_to_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (advance_en && hit) |=> order_q[NUM_THREADS-1] == $past(hit_tid));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(advance_en && hit) |=> $stable(order_flat));
endmodule

// File: rtl/fetch_thread_pick.sv
module fetch_thread_pick
  import fetch_pick_pkg::*;
#(
  parameter int NUM_THREADS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_THREADS*STAT_W-1:0] thr_status,
  input  logic [NUM_THREADS-1:0]        thr_active,
  input  logic [1:0]                    policy_sel,
  input  logic                          advance,
  output logic [TID_W-1:0]              pick_tid,
  output logic                          pick_valid
);
  logic [NUM_THREADS-1:0] can_fetch;
  logic [NUM_THREADS-1:0] cand;
  logic [MAX_THREADS-1:0] can_pad;

  assign can_pad = MAX_THREADS'(can_fetch);

  fetch_pick_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
    .thr_status (thr_status),
    .thr_active (thr_active),
    .can_fetch  (can_fetch),
    .cand       (cand)
  );

  if (NUM_THREADS == 1) begin : g_one
    // single-thread bypass, policy is not consulted
    assign pick_valid = cand[0];
    assign pick_tid   = '0;

    assert_bypass_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pick_valid |-> (thr_active[0] && can_pad[0]));
  end else begin : g_multi
    logic             rot_hit;
    logic [TID_W-1:0] rot_tid;
    logic             fa_any;
    logic [TID_W-1:0] fa_idx;
    logic             fa_valid;
    logic             rot_adv;

    assign rot_adv = advance & (policy_sel == POL_ROTATE);

    fetch_pick_rotor #(.NUM_THREADS(NUM_THREADS)) u_rotor (
      .clk        (clk),
      .rst_n      (rst_n),
      .cand       (cand),
      .advance_en (rot_adv),
      .hit        (rot_hit),
      .hit_tid    (rot_tid)
    );

    // lowest-numbered active thread
    always_comb begin
      fa_any = 1'b0;
      fa_idx = '0;
      for (int t = 0; t < NUM_THREADS; t++) begin
        if (!fa_any && thr_active[t]) begin
          fa_any = 1'b1;
          fa_idx = TID_W'(t);
        end
      end
    end
    assign fa_valid = fa_any & can_pad[fa_idx];

    always_comb begin
      pick_valid = 1'b0;
      pick_tid   = '0;
      case (policy_sel)
        POL_SOLO: begin
          pick_valid = 1'b1;
          pick_tid   = '0;
        end
        POL_ROTATE: begin
          pick_valid = rot_hit;
          pick_tid   = rot_tid;
        end
        POL_FIRST_ACT: begin
          pick_valid = fa_valid;
          pick_tid   = fa_valid ? fa_idx : '0;
        end
        default: begin
          pick_valid = 1'b0;
          pick_tid   = '0;
        end
      endcase
    end

    assert_solo_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_sel == POL_SOLO) |-> (pick_valid && pick_tid == '0));
    assert_bad_policy_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (policy_sel == POL_BAD) |-> !pick_valid);
    assert_status_ok_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (pick_valid && policy_sel != POL_SOLO) |-> can_pad[pick_tid]);
  end

  assert_tid_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !pick_valid |-> pick_tid == '0);
endmodule

// File: tb/fetch_thread_pick_bench.sv
module fetch_thread_pick_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] st;
  logic [3:0]  act;
  logic [1:0]  pol;
  logic        adv;
  logic [1:0]  tid4, tid1;
  logic        v4, v1;

  int total = 0;
  int bad = 0;
  int mlist [4];
  bit finished = 1'b0;
  logic [31:0] seed = 32'h1ACE_B00C;

  always #2 clk = ~clk;

  fetch_thread_pick #(.NUM_THREADS(4)) u_fetch_thread_pick (
    .clk(clk), .rst_n(rst_n), .thr_status(st), .thr_active(act),
    .policy_sel(pol), .advance(adv), .pick_tid(tid4), .pick_valid(v4));

  fetch_thread_pick #(.NUM_THREADS(1)) u_single (
    .clk(clk), .rst_n(rst_n), .thr_status(st[2:0]), .thr_active(act[0:0]),
    .policy_sel(pol), .advance(adv), .pick_tid(tid1), .pick_valid(v1));

  function automatic bit ok_code(input logic [2:0] c);
    return (c == 3'd0) || (c == 3'd1) || (c == 3'd4);
  endfunction

  function automatic logic [11:0] pk(input int c3, input int c2, input int c1, input int c0);
    return {c3[2:0], c2[2:0], c1[2:0], c0[2:0]};
  endfunction

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  task automatic check(input string req, input logic gv, input logic [1:0] gt,
                       input logic ev, input logic [1:0] et);
    total++;
    if (gv !== ev || gt !== et) begin
      bad++;
      $display("FAIL %s: got valid=%0d tid=%0d expected valid=%0d tid=%0d",
               req, gv, gt, ev, et);
    end
  endtask

  task automatic step(input string req, input logic [11:0] s, input logic [3:0] a,
                      input logic [1:0] p, input logic ad);
    logic ev;
    logic [1:0] et;
    logic e1;
    int lo;
    @(negedge clk);
    st = s; act = a; pol = p; adv = ad;
    #1;
    ev = 1'b0; et = 2'd0;
    case (p)
      2'd0: begin ev = 1'b1; et = 2'd0; end
      2'd1: begin
        for (int q = 0; q < 4; q++) begin
          if (!ev && a[mlist[q]] && ok_code(s[mlist[q]*3 +: 3])) begin
            ev = 1'b1; et = 2'(mlist[q]);
          end
        end
      end
      2'd2: begin
        lo = -1;
        for (int t = 3; t >= 0; t--) if (a[t]) lo = t;
        if (lo >= 0 && ok_code(s[lo*3 +: 3])) begin ev = 1'b1; et = 2'(lo); end
      end
      default: ev = 1'b0;
    endcase
    check(req, v4, tid4, ev, et);
    e1 = a[0] && ok_code(s[2:0]);
    check("R8", v1, tid1, e1, 2'd0);
    @(posedge clk);
    if (p == 2'd1 && ad && ev) begin
      int pos;
      int w;
      pos = 0;
      for (int q = 0; q < 4; q++) if (mlist[q] == int'(et)) pos = q;
      w = mlist[pos];
      for (int q = pos; q < 3; q++) mlist[q] = mlist[q+1];
      mlist[3] = w;
    end
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      finished = 1'b1;
      bad++;
      total++;
      $display("FAIL watchdog: got running expected finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    string tag;
    rst_n = 1'b0;
    st = '0; act = '0; pol = 2'd1; adv = 1'b0;
    for (int i = 0; i < 4; i++) mlist[i] = i;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R2: reset order, no advance then a full rotation
    step("R2", pk(0,0,0,0), 4'hF, 2'd1, 1'b0);
    for (int k = 0; k < 5; k++) step("R2", pk(0,0,0,0), 4'hF, 2'd1, 1'b1);
    // R4: no advance keeps the order
    step("R4", pk(0,0,0,0), 4'hF, 2'd1, 1'b0);
    step("R4", pk(0,0,0,0), 4'hF, 2'd1, 1'b0);
    // R3 / R1: skip threads that cannot fetch or are inactive
    step("R3", pk(0,4,3,5), 4'hF, 2'd1, 1'b1);
    step("R1", pk(6,2,7,1), 4'hF, 2'd1, 1'b1);
    step("R3", pk(0,0,0,0), 4'b1010, 2'd1, 1'b1);
    // R5: nothing qualifies, advance has no effect
    step("R5", pk(3,2,5,6), 4'hF, 2'd1, 1'b1);
    step("R5", pk(0,0,0,0), 4'h0, 2'd1, 1'b1);
    step("R5", pk(0,0,0,0), 4'hF, 2'd1, 1'b0);
    // R6: single policy ignores status and mask
    step("R6", pk(3,3,3,3), 4'h0, 2'd0, 1'b1);
    step("R6", pk(7,2,5,6), 4'h6, 2'd0, 1'b0);
    // R4: advance under another policy leaves the list alone
    step("R4", pk(0,0,0,0), 4'hF, 2'd1, 1'b0);
    // R7: first active thread only
    step("R7", pk(0,1,3,3), 4'b0100, 2'd2, 1'b0);
    step("R7", pk(0,2,0,0), 4'b1100, 2'd2, 1'b0);
    step("R7", pk(0,0,0,0), 4'b0000, 2'd2, 1'b0);
    step("R7", pk(0,0,4,2), 4'b1110, 2'd2, 1'b0);
    // R9 / R10: unsupported policy
    step("R9", pk(0,0,0,0), 4'hF, 2'd3, 1'b1);
    step("R10", pk(3,3,3,3), 4'hF, 2'd1, 1'b0);

    for (int n = 0; n < 4000; n++) begin
      logic [31:0] r;
      seed = nxt(seed);
      r = seed;
      case (r[17:16])
        2'd0: tag = "R6";
        2'd1: tag = "R3";
        2'd2: tag = "R7";
        default: tag = "R9";
      endcase
      step(tag, r[11:0], r[15:12] | {3'b000, r[20]}, r[17:16], r[18]);
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule